// File: doc/BRIEF.md
# SPI Interrupt Status Aggregator

This block keeps the interrupt state of an SPI controller and drives one level-sensitive interrupt line. It sits between the controller's register bus and its FIFO and shift logic. Three 32-bit registers can be reached over a word-aligned write/read port: a master interrupt enable, a sticky status register and a per-source enable mask. Reads are combinational.

The FIFO and transfer logic report through six inputs. Two are levels: RX not empty and RX full. Four are single-cycle pulses: a received byte arriving, a byte transfer finishing, a TX underrun and TX half empty. Each input sets its status bit. Software toggles status bits by writing a mask, because a write XORs into the register. Level conditions set their bits again on every cycle they are present, so a level source cannot be cleared while its condition holds. A controller soft-reset pulse clears all interrupt state.

Top module: `spi_irq_agg`

## Requirements
- R1: Register offsets are byte addresses on `addr_i`. Master enable is at 0x1C with the enable in bit 31. Status is at 0x20. Enable mask is at 0x28. Any other offset reads zero and ignores writes. Bits that are not implemented read zero.
- R2: The status bits are: TX empty = 2, TX underrun = 3, RX full = 4, RX overrun = 5, TX half empty = 6, RX not empty = 8. Together they form the implemented mask 0x17C, which also applies to the enable mask.
- R3: A write to the status offset replaces the status with (status XOR wdata) restricted to the implemented mask, so every written one flips its bit.
- R4: In any cycle where `rx_nempty_i` or `rx_full_i` is high, bit 8 or bit 4 respectively is set after that clock edge. This also happens after software has toggled the bit off.
- R5: A `rx_push_i` pulse that arrives while `rx_full_i` is high sets the overrun bit 5. A push while the FIFO is not full does not set bit 5.
- R6: A `byte_done_i` pulse sets both bit 2 and bit 8.
- R7: A `tx_under_i` pulse sets bit 3. A `tx_half_i` pulse sets bit 6.
- R8: `irq_o` is a register. After each clock edge it equals master enable AND (status AND enable mask is nonzero), evaluated on the register values written at that same edge.
- R9: When a status write and a set event coincide on the same bit, the bit ends set.
- R10: `soft_rst_i` clears all three registers and `irq_o` at the next edge. It overrides any write or event in that cycle.
- R11: The asynchronous reset `rst_ni` brings all registers and `irq_o` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Controller soft reset pulse |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| rx_nempty_i | input | 1 | RX FIFO holds data (level) |
| rx_full_i | input | 1 | RX FIFO full (level) |
| rx_push_i | input | 1 | Received byte arriving (pulse) |
| byte_done_i | input | 1 | One byte transfer finished (pulse) |
| tx_under_i | input | 1 | TX underrun (pulse) |
| tx_half_i | input | 1 | TX FIFO half empty (pulse) |
| irq_o | output | 1 | Interrupt request (level) |

## Verification
Every register result, including `irq_o`, is due one clock edge after the cycle in which its write or event is presented. Read data follows `addr_i` with no clock at all. The bench drives inputs on the falling edge and returns them to idle on the next falling edge. Just after that falling edge it compares read data and `irq_o` against a model that advanced exactly once at the rising edge between. This makes each check fall one edge after its stimulus and before any later stimulus can take effect. Idle cycles carry no events and leave the model unchanged, so no check depends on how long the bench waits.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int B_TXE  = 2;
  localparam int B_TXUR = 3;
  localparam int B_RXF  = 4;
  localparam int B_RXOV = 5;
  localparam int B_TXHE = 6;
  localparam int B_RXNE = 8;
  localparam int B_GIE  = 31;

  localparam logic [7:0] OFF_GIE  = 8'h1C;
  localparam logic [7:0] OFF_STAT = 8'h20;
  localparam logic [7:0] OFF_EN   = 8'h28;

  localparam logic [31:0] ST_MASK = (32'd1 << B_TXE) | (32'd1 << B_TXUR) | (32'd1 << B_RXF)
                                  | (32'd1 << B_RXOV) | (32'd1 << B_TXHE) | (32'd1 << B_RXNE);

  typedef struct packed {
    logic rx_nempty;
    logic rx_full;
    logic rx_push;
    logic byte_done;
    logic tx_under;
    logic tx_half;
  } evt_t;
endpackage

// File: rtl/spi_irq_evmap.sv
module spi_irq_evmap
  import spi_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  evt_t              ev_i,
  output logic [DATA_W-1:0] set_o
);
  always_comb begin
    set_o = '0;
    if (ev_i.rx_nempty || ev_i.byte_done) set_o[B_RXNE] = 1'b1;
    if (ev_i.rx_full)                     set_o[B_RXF]  = 1'b1;
    // byte dropped when the FIFO is already full
    if (ev_i.rx_push && ev_i.rx_full)     set_o[B_RXOV] = 1'b1;
    if (ev_i.byte_done)                   set_o[B_TXE]  = 1'b1;
    if (ev_i.tx_under)                    set_o[B_TXUR] = 1'b1;
    if (ev_i.tx_half)                     set_o[B_TXHE] = 1'b1;
  end
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] set_i,
  output logic [DATA_W-1:0] st_q_o,
  output logic [DATA_W-1:0] st_d_o
);
  localparam logic [DATA_W-1:0] MASK = DATA_W'(ST_MASK);

  logic [DATA_W-1:0] st_q, toggled;

  always_comb begin
    toggled = wr_i ? ((st_q ^ wdata_i) & MASK) : st_q;
    st_d_o  = soft_rst_i ? '0 : (toggled | (set_i & MASK));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d_o;
  end

  assign st_q_o = st_q;

  assert_soft_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (st_q == '0));
  assert_level_rxne_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i[B_RXNE] && !soft_rst_i) |=> st_q[B_RXNE]);
  assert_overrun_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i[B_RXOV] && !soft_rst_i) |=> st_q[B_RXOV]);
  assert_toggle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !soft_rst_i && set_i == '0) |=> (st_q == $past((st_q ^ wdata_i) & MASK)));
  assert_unused_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q & ~MASK) == '0);
endmodule

// File: rtl/spi_irq_cfg.sv
module spi_irq_cfg
  import spi_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              gie_wr_i,
  input  logic              en_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              gie_q_o,
  output logic              gie_d_o,
  output logic [DATA_W-1:0] en_q_o,
  output logic [DATA_W-1:0] en_d_o
);
  localparam logic [DATA_W-1:0] MASK = DATA_W'(ST_MASK);

  logic              gie_q;
  logic [DATA_W-1:0] en_q;

  always_comb begin
    gie_d_o = soft_rst_i ? 1'b0 : (gie_wr_i ? wdata_i[B_GIE] : gie_q);
    en_d_o  = soft_rst_i ? '0   : (en_wr_i  ? (wdata_i & MASK) : en_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q <= 1'b0;
      en_q  <= '0;
    end else begin
      gie_q <= gie_d_o;
      en_q  <= en_d_o;
    end
  end

  assign gie_q_o = gie_q;
  assign en_q_o  = en_q;

  assert_cfg_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (!gie_q && en_q == '0));
  assert_cfg_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!soft_rst_i && !gie_wr_i && !en_wr_i) |=> ($stable(gie_q) && $stable(en_q)));
endmodule

// File: rtl/spi_irq_agg.sv
module spi_irq_agg
  import spi_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              rx_nempty_i,
  input  logic              rx_full_i,
  input  logic              rx_push_i,
  input  logic              byte_done_i,
  input  logic              tx_under_i,
  input  logic              tx_half_i,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_GIE  = ADDR_W'(OFF_GIE);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFF_EN);

  evt_t              ev;
  logic [DATA_W-1:0] set_vec, st_q, st_d, en_q, en_d;
  logic              gie_q, gie_d, irq_q;
  logic              sel_gie, sel_stat, sel_en;

  assign ev = '{rx_nempty: rx_nempty_i, rx_full: rx_full_i, rx_push: rx_push_i,
                byte_done: byte_done_i, tx_under: tx_under_i, tx_half: tx_half_i};

  assign sel_gie  = (addr_i == A_GIE);
  assign sel_stat = (addr_i == A_STAT);
  assign sel_en   = (addr_i == A_EN);

  spi_irq_evmap #(.DATA_W(DATA_W)) u_evmap (
    .ev_i  (ev),
    .set_o (set_vec)
  );

  spi_irq_status #(.DATA_W(DATA_W)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .wr_i       (wr_en_i && sel_stat),
    .wdata_i    (wdata_i),
    .set_i      (set_vec),
    .st_q_o     (st_q),
    .st_d_o     (st_d)
  );

  spi_irq_cfg #(.DATA_W(DATA_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .gie_wr_i   (wr_en_i && sel_gie),
    .en_wr_i    (wr_en_i && sel_en),
    .wdata_i    (wdata_i),
    .gie_q_o    (gie_q),
    .gie_d_o    (gie_d),
    .en_q_o     (en_q),
    .en_d_o     (en_d)
  );

  // registered from next-state so irq tracks the registers on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= gie_d && |(st_d & en_d);
  end

  always_comb begin
    rdata_o = '0;
    if (sel_gie)  rdata_o[B_GIE] = gie_q;
    if (sel_stat) rdata_o = st_q;
    if (sel_en)   rdata_o = en_q;
  end

  assign irq_o = irq_q;

  assert_irq_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (gie_q && |(st_q & en_q)));
  assert_irq_raise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gie_q && |(st_q & en_q)) |-> irq_o);
  assert_irq_soft_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !irq_o);
  assert_sel_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sel_gie, sel_stat, sel_en}));
endmodule

// File: tb/tb_spi_irq_agg.sv
module tb_spi_irq_agg;
  localparam int CLK_P = 10;
  localparam logic [31:0] MASK = 32'h0000_017C;

  logic        clk_i = 1'b0, rst_ni = 1'b0, soft_rst_i = 1'b0, wr_en_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        rx_nempty_i = 0, rx_full_i = 0, rx_push_i = 0, byte_done_i = 0;
  logic        tx_under_i = 0, tx_half_i = 0, irq_o;

  int runs = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_st = '0, m_en = '0;
  logic        m_gie = 1'b0, m_irq = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  spi_irq_agg dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr_i = a;
    #1 v = rdata_o;
  endtask

  // bit order of ev: {rx_nempty, rx_full, rx_push, byte_done, tx_under, tx_half}
  task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] wd,
                     input logic [5:0] ev, input logic srst);
    logic [31:0] setv;
    wr_en_i = we; addr_i = a; wdata_i = wd; soft_rst_i = srst;
    {rx_nempty_i, rx_full_i, rx_push_i, byte_done_i, tx_under_i, tx_half_i} = ev;
    @(posedge clk_i);
    setv = '0;
    if (ev[5] || ev[2]) setv[8] = 1;
    if (ev[4])          setv[4] = 1;
    if (ev[3] && ev[4]) setv[5] = 1;
    if (ev[2])          setv[2] = 1;
    if (ev[1])          setv[3] = 1;
    if (ev[0])          setv[6] = 1;
    if (srst) begin
      m_st = '0; m_en = '0; m_gie = 0;
    end else begin
      if (we && a == 8'h1C) m_gie = wd[31];
      if (we && a == 8'h20) m_st = (m_st ^ wd) & MASK;
      if (we && a == 8'h28) m_en = wd & MASK;
      m_st = m_st | setv;
    end
    m_irq = m_gie && ((m_st & m_en) != 0);
    @(negedge clk_i);
    wr_en_i = 0; soft_rst_i = 0; wdata_i = '0;
    {rx_nempty_i, rx_full_i, rx_push_i, byte_done_i, tx_under_i, tx_half_i} = '0;
  endtask

  task automatic chk_all(input string req);
    logic [31:0] v;
    rd(8'h20, v); chk({req, " status"}, v, m_st);
    rd(8'h28, v); chk({req, " enable"}, v, m_en);
    rd(8'h1C, v); chk({req, " gie"}, v, {m_gie, 31'd0});
    chk({req, " irq"}, {31'd0, irq_o}, {31'd0, m_irq});
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk_i);
    chk_all("R11 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 offsets, unused bits and unmapped offsets
    cyc(1, 8'h28, 32'hFFFF_FFFF, 6'd0, 0);
    cyc(1, 8'h1C, 32'hFFFF_FFFF, 6'd0, 0);
    chk_all("R1 map");
    cyc(1, 8'h24, 32'hFFFF_FFFF, 6'd0, 0);
    rd(8'h24, v); chk("R1 unmapped read", v, 32'd0);
    chk_all("R1 unmapped write");

    // R2 R4 R5 R6 R7: every event combination, then clear by toggling
    for (int e = 0; e < 64; e++) begin
      cyc(0, 8'h00, 32'd0, 6'(e), 0);
      chk_all("R2 R4 R5 R6 R7 R8 events");
      cyc(1, 8'h20, m_st, 6'd0, 0);
      chk_all("R3 clear");
    end

    // R3 toggle sweep
    for (int i = 0; i < 32; i++) begin
      cyc(1, 8'h20, 32'h1111_1111 * i ^ (32'hA5 << (i % 8)), 6'd0, 0);
      chk_all("R3 toggle");
    end

    // R9 write-toggle coinciding with set events
    cyc(1, 8'h20, m_st ^ 32'h17C, 6'd0, 0);
    cyc(1, 8'h20, 32'h0000_017C, 6'b110111, 0);
    chk_all("R9 set wins");

    // R4 level re-sets bit after toggle-off while held
    cyc(1, 8'h20, m_st & 32'h110, 6'b110000, 0);
    chk_all("R4 level persists");

    // R8 enable / gie sweep with status all ones
    cyc(1, 8'h20, m_st ^ MASK, 6'd0, 0);
    for (int g = 0; g < 2; g++) begin
      for (int b = 0; b < 10; b++) begin
        cyc(1, 8'h1C, {g[0], 31'd0}, 6'd0, 0);
        cyc(1, 8'h28, 32'd1 << b, 6'd0, 0);
        chk_all("R8 irq gating");
      end
    end

    // R8 irq drops when status bit toggled off
    cyc(1, 8'h1C, 32'h8000_0000, 6'd0, 0);
    cyc(1, 8'h28, 32'h0000_0008, 6'd0, 0);
    cyc(1, 8'h20, 32'h0000_0008, 6'd0, 0);
    chk_all("R8 irq fall");

    // R10 soft reset beats writes and events
    cyc(0, 8'h00, 32'd0, 6'b111111, 0);
    cyc(1, 8'h28, MASK, 6'd0, 0);
    cyc(1, 8'h20, 32'h0000_0004, 6'b111111, 1);
    chk_all("R10 soft reset");
    rd(8'h20, v); chk("R10 status zero", v, 32'd0);
    chk("R10 irq low", {31'd0, irq_o}, 32'd0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule